// File: doc/BRIEF.md
# Low-Side Driver Fault Diagnoser

This block is the host end of a fault check on an eight-channel serial low-side driver. A client asks for a check by giving a control byte and pulsing `start`. The block runs three steps in order. It shifts the byte out over a four-wire serial link to program the driver. It then waits a fixed settle time, so that inrush blanking ends and any overloaded output has been released. Last, it shifts the same byte out again and collects the byte the driver returns during that second transfer.

Each returned bit shows the voltage level seen on one output pin. A 0 in the control byte turns a channel on and a 1 turns it off. On a healthy channel the returned bit therefore equals the bit that was sent. When they differ, the block uses the commanded bit to decide the kind of fault. A channel commanded on that still reads high is reported as shorted or overloaded. A channel commanded off that reads low is reported as an open load. Both masks appear together with a one-cycle `done` pulse.

The link runs in mode-like fashion. The select line is low for the whole byte, and the clock is low whenever select changes. Data goes out most significant bit first, which is channel 7. The driver samples on the falling clock edge and the host samples the returned data at that same falling edge. Lead, lag, clock high and clock low times are set as parameters counted in system clock cycles.

Top module: `drv_fault_diag`

## Requirements
- R1: After synchronous reset the outputs are: `spi_ce` high, `spi_sclk` low, `busy` low, `done` low, and both fault masks zero.
- R2: Each transfer sends the byte most significant bit (channel 7) first. `spi_si` is valid before the first rising clock edge and changes only together with a rising clock edge. It is held for the whole high phase, so a slave that samples on the falling edge receives the byte unchanged.
- R3: `spi_ce` is held low for exactly 8 clock pulses per transfer. `spi_sclk` is low in every cycle in which `spi_ce` changes, and it is never high while `spi_ce` is high.
- R4: Every clock high phase and every clock low phase lasts at least HALF_CYC cycles. The time from select falling to the first rising edge is at least LEAD_CYC cycles. The time from the last falling edge to select rising is at least LAG_CYC cycles.
- R5: A check makes two transfers, both carrying the byte captured at `start`. The second select falling edge comes no earlier than SETTLE_CYC cycles, and no later than SETTLE_CYC+4 cycles, after the first select rising edge.
- R6: When every returned bit equals the sent bit, both masks are zero.
- R7: Bit i of `short_mask` is 1 exactly when sent bit i is 0 and returned bit i is 1. A high readback on a channel commanded off is not flagged.
- R8: Bit i of `open_mask` is 1 exactly when sent bit i is 1 and returned bit i is 0.
- R9: `busy` goes high in the cycle after `start` is accepted and stays high until `done`. `done` is high for exactly one cycle, with `busy` low. The masks change only in that cycle and hold until the next `done`.
- R10: A `start` pulse while `busy` is high is ignored. The running check keeps its original byte in both transfers and in the decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a check of `req_byte` (accepted when idle) |
| req_byte | input | 8 | Control byte, bit i drives channel i (0 = on, 1 = off) |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle pulse: fault masks are valid |
| short_mask | output | 8 | Per-channel short or overload flags |
| open_mask | output | 8 | Per-channel open-load flags |
| spi_ce | output | 1 | Active-low select to the driver |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_si | output | 1 | Serial data to the driver |
| spi_so | input | 1 | Serial diagnostic data from the driver |

## Verification
On every cycle the assertions check the link discipline. This covers the clock being low at each select edge and never high while deselected, data holding still through each high phase, and every high phase lasting at least HALF_CYC. They also check the handshake: `done` is a single cycle with `busy` low, the masks are frozen outside `done`, the byte is held while busy, and the settle count has elapsed before the second transfer. Some behaviour shows only in the bench scenarios, which run against a model of the driver that injects shorts and opens. These are the decoding of returned bits into the two masks, the bit order as the slave latches it, the pulse count per select window, and the lead, lag and low-phase times.

// File: rtl/diag_pkg.sv
package diag_pkg;

    parameter int CH = 8;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_XFER1,
        SQ_SETTLE,
        SQ_XFER2
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HIGH,
        PH_LOW,
        PH_LAG
    } phase_t;

    typedef struct packed {
        logic [CH-1:0] shorted;
        logic [CH-1:0] open;
    } fault_t;

    // sent bit 0 = on, 1 = off; returned bit = pin level (1 = high)
    function automatic fault_t classify(input logic [CH-1:0] sent,
                                        input logic [CH-1:0] rcvd);
        fault_t f;
        f.shorted = ~sent & rcvd;
        f.open    = sent & ~rcvd;
        return f;
    endfunction

endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer
    import diag_pkg::*;
#(
    parameter int LEAD_CYC = 30,
    parameter int HALF_CYC = 25,
    parameter int LAG_CYC  = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [CH-1:0] tx_byte,
    output logic          xfer_done,
    output logic [CH-1:0] rx_byte,
    output logic          spi_ce,
    output logic          spi_sclk,
    output logic          spi_si,
    input  logic          spi_so
);

    localparam int MAXC = (LEAD_CYC > HALF_CYC) ?
                          ((LEAD_CYC > LAG_CYC) ? LEAD_CYC : LAG_CYC) :
                          ((HALF_CYC > LAG_CYC) ? HALF_CYC : LAG_CYC);
    localparam int TW   = $clog2(MAXC + 1);
    localparam int BW   = $clog2(CH);

    phase_t        ph;
    logic [TW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [CH-1:0] tx_sr;
    logic [CH-1:0] rx_sr;

    assign spi_si  = tx_sr[CH-1];
    assign rx_byte = rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            spi_ce    <= 1'b1;
            spi_sclk  <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (go) begin
                        tx_sr  <= tx_byte;
                        bitn   <= '0;
                        spi_ce <= 1'b0;
                        cnt    <= TW'(LEAD_CYC - 1);
                        ph     <= PH_LEAD;
                    end
                end
                PH_LEAD: begin
                    if (cnt == '0) begin
                        spi_sclk <= 1'b1;
                        cnt      <= TW'(HALF_CYC - 1);
                        ph       <= PH_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        spi_sclk <= 1'b0;
                        rx_sr    <= {rx_sr[CH-2:0], spi_so};
                        bitn     <= bitn + 1'b1;
                        if (bitn == BW'(CH - 1)) begin
                            cnt <= TW'(LAG_CYC - 1);
                            ph  <= PH_LAG;
                        end else begin
                            cnt <= TW'(HALF_CYC - 1);
                            ph  <= PH_LOW;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        spi_sclk <= 1'b1;
                        tx_sr    <= {tx_sr[CH-2:0], 1'b0};
                        cnt      <= TW'(HALF_CYC - 1);
                        ph       <= PH_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_LAG: begin
                    if (cnt == '0) begin
                        spi_ce    <= 1'b1;
                        xfer_done <= 1'b1;
                        ph        <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // checker: length of the current clock high phase, saturating
    logic [TW-1:0] hrun;
    always_ff @(posedge clk) begin
        if (rst)                        hrun <= '0;
        else if (!spi_sclk)             hrun <= '0;
        else if (hrun != TW'(HALF_CYC)) hrun <= hrun + 1'b1;
    end

    p_sclk_gated_r3: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_ce);

    p_ce_edge_low_r3: assert property (@(posedge clk) disable iff (rst)
        (spi_ce != $past(spi_ce)) |-> !spi_sclk);

    p_si_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_si));

    p_high_time_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_sclk) |-> (hrun >= TW'(HALF_CYC)));

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic fire
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            run  <= 1'b0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (arm) begin
                cnt <= CW'(SETTLE_CYC - 1);
                run <= 1'b1;
            end else if (run) begin
                if (cnt == '0) begin
                    run  <= 1'b0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fault_decoder.sv
module fault_decoder
    import diag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [CH-1:0] sent,
    input  logic [CH-1:0] rcvd,
    output fault_t        faults
);

    always_ff @(posedge clk) begin
        if (rst)          faults <= '0;
        else if (capture) faults <= classify(sent, rcvd);
    end

endmodule

// File: rtl/drv_fault_diag.sv
module drv_fault_diag
    import diag_pkg::*;
#(
    parameter int SETTLE_CYC = 25000,
    parameter int LEAD_CYC   = 30,
    parameter int HALF_CYC   = 25,
    parameter int LAG_CYC    = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CH-1:0] req_byte,
    output logic          busy,
    output logic          done,
    output logic [CH-1:0] short_mask,
    output logic [CH-1:0] open_mask,
    output logic          spi_ce,
    output logic          spi_sclk,
    output logic          spi_si,
    input  logic          spi_so
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    seq_state_t    st;
    logic [CH-1:0] byte_q;
    logic          go;
    logic          x_done;
    logic [CH-1:0] rx_byte;
    logic [CH-1:0] tx_sel;
    logic          arm;
    logic          fire;
    logic          capture;
    fault_t        faults;

    assign go      = ((st == SQ_IDLE) && start) || ((st == SQ_SETTLE) && fire);
    assign tx_sel  = (st == SQ_IDLE) ? req_byte : byte_q;
    assign arm     = (st == SQ_XFER1) && x_done;
    assign capture = (st == SQ_XFER2) && x_done;
    assign busy    = (st != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            byte_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE:   if (start) begin
                               byte_q <= req_byte;
                               st     <= SQ_XFER1;
                           end
                SQ_XFER1:  if (x_done) st <= SQ_SETTLE;
                SQ_SETTLE: if (fire)   st <= SQ_XFER2;
                SQ_XFER2:  if (x_done) begin
                               st   <= SQ_IDLE;
                               done <= 1'b1;
                           end
                default:   st <= SQ_IDLE;
            endcase
        end
    end

    spi_byte_xfer #(
        .LEAD_CYC (LEAD_CYC),
        .HALF_CYC (HALF_CYC),
        .LAG_CYC  (LAG_CYC)
    ) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .tx_byte   (tx_sel),
        .xfer_done (x_done),
        .rx_byte   (rx_byte),
        .spi_ce    (spi_ce),
        .spi_sclk  (spi_sclk),
        .spi_si    (spi_si),
        .spi_so    (spi_so)
    );

    settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .arm  (arm),
        .fire (fire)
    );

    fault_decoder u_dec (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .sent    (byte_q),
        .rcvd    (rx_byte),
        .faults  (faults)
    );

    assign short_mask = faults.shorted;
    assign open_mask  = faults.open;

    // checker: cycles since the first transfer ended, saturating
    logic [CW-1:0] since;
    always_ff @(posedge clk) begin
        if (rst)                          since <= '0;
        else if (arm)                     since <= '0;
        else if (since != CW'(SETTLE_CYC)) since <= since + 1'b1;
    end

    p_settle_gap_r5: assert property (@(posedge clk) disable iff (rst)
        ((st == SQ_SETTLE) && fire) |-> (since >= CW'(SETTLE_CYC)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    p_masks_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(short_mask) && $stable(open_mask)));

    p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(byte_q));

endmodule

// File: tb/drv_fault_diag_tb.sv
module drv_fault_diag_tb;

    localparam int SETTLE = 400;
    localparam int LEAD   = 30;
    localparam int HALF   = 25;
    localparam int LAG    = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       busy, done, spi_ce, spi_sclk, spi_si;
    logic [7:0] short_mask, open_mask;
    logic       spi_so = 1'b0;

    always #5 clk = ~clk;

    drv_fault_diag #(
        .SETTLE_CYC (SETTLE),
        .LEAD_CYC   (LEAD),
        .HALF_CYC   (HALF),
        .LAG_CYC    (LAG)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_byte   (req_byte),
        .busy       (busy),
        .done       (done),
        .short_mask (short_mask),
        .open_mask  (open_mask),
        .spi_ce     (spi_ce),
        .spi_sclk   (spi_sclk),
        .spi_si     (spi_si),
        .spi_so     (spi_so)
    );

    int vecs = 0;
    int errs = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- driver model ----------------
    logic [7:0] inj_short = 8'h00;
    logic [7:0] inj_open  = 8'h00;
    logic [7:0] drv_latch = 8'hFF;
    logic [7:0] drv_sh    = 8'h00;
    logic [7:0] lat_hist [0:3];
    int         lat_n = 0;
    int         pulses = 0;
    int         pulse_bad = 0;

    function automatic logic [7:0] pin_levels(input logic [7:0] lat);
        logic [7:0] v;
        for (int i = 0; i < 8; i++)
            v[i] = lat[i] ? ~inj_open[i] : inj_short[i];
        return v;
    endfunction

    always @(negedge spi_ce) if (!rst) begin
        drv_sh = pin_levels(drv_latch);
        pulses = 0;
    end
    always @(posedge spi_ce) if (!rst) begin
        drv_latch = drv_sh;
        if (lat_n < 4) lat_hist[lat_n] = drv_sh;
        lat_n++;
        if (pulses != 8) pulse_bad++;
    end
    always @(posedge spi_sclk) if (!rst) begin
        spi_so = drv_sh[7];
        pulses++;
    end
    always @(negedge spi_sclk) if (!rst) drv_sh = {drv_sh[6:0], spi_si};

    // ---------------- link timing monitor ----------------
    int  cyc = 0, t_rise = 0, last_gap = 0;
    int  hi_run = 0, lo_run = 0;
    int  tviol = 0, ceviol = 0;
    bit  first_edge = 1'b0;
    logic p_sclk = 1'b0, p_ce = 1'b1;

    always @(negedge clk) if (!rst) begin
        cyc++;
        if (spi_sclk && !p_sclk) begin
            if (first_edge) begin
                if (lo_run < LEAD) tviol++;
                first_edge = 1'b0;
            end else if (lo_run < HALF) tviol++;
        end
        if (!spi_sclk && p_sclk && hi_run < HALF) tviol++;
        if (spi_ce && !p_ce) begin
            if (lo_run < LAG) tviol++;
            t_rise = cyc;
        end
        if (!spi_ce && p_ce) begin
            last_gap   = cyc - t_rise;
            first_edge = 1'b1;
            lo_run     = 0;
        end
        if ((spi_ce != p_ce) && (spi_sclk || p_sclk)) ceviol++;
        if (spi_sclk && spi_ce) ceviol++;
        if (spi_sclk) begin hi_run++; lo_run = 0; end
        else          begin lo_run++; hi_run = 0; end
        p_sclk = spi_sclk;
        p_ce   = spi_ce;
    end

    // ---------------- scenarios ----------------
    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ce", spi_ce, 1);
        chk("R1 sclk", spi_sclk, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 masks", {short_mask, open_mask}, 0);
    endtask

    task automatic t_run(input logic [7:0] b, input logic [7:0] sh, input logic [7:0] op);
        bit ok;
        inj_short = sh;
        inj_open  = op;
        lat_n     = 0;
        @(negedge clk);
        start = 1'b1; req_byte = b;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", busy, 1);
        wait_done(ok);
        chk("R9 done seen", ok, 1);
        chk("R9 busy low at done", busy, 0);
        chk("R7 short mask", short_mask, ~b & sh);
        chk("R8 open mask", open_mask, b & op);
        if (sh == 0 && op == 0) chk("R6 clean", {short_mask, open_mask}, 0);
        chk("R5 two transfers", lat_n, 2);
        chk("R2 first byte", lat_hist[0], b);
        chk("R5 second byte", lat_hist[1], b);
        chk("R5 settle min", last_gap >= SETTLE, 1);
        chk("R5 settle max", last_gap <= SETTLE + 4, 1);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R9 masks hold", {short_mask, open_mask}, {~b & sh, b & op});
    endtask

    task automatic t_busy_ignore();
        bit ok;
        inj_short = 8'h00;
        inj_open  = 8'h33;
        lat_n     = 0;
        @(negedge clk);
        start = 1'b1; req_byte = 8'h33;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        start = 1'b1; req_byte = 8'hCC;
        @(negedge clk);
        start = 1'b0;
        repeat (500) @(negedge clk);
        start = 1'b1; req_byte = 8'hCC;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk("R10 done seen", ok, 1);
        chk("R10 first byte kept", lat_hist[0], 8'h33);
        chk("R10 second byte kept", lat_hist[1], 8'h33);
        chk("R10 open mask", open_mask, 8'h33);
        chk("R10 short mask", short_mask, 8'h00);
        repeat (3) @(negedge clk);
        chk("R10 no extra check", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run(8'hA5, 8'h00, 8'h00);
        t_run(8'h00, 8'h81, 8'h00);
        t_run(8'hFF, 8'h00, 8'h3C);
        t_run(8'h5A, 8'hFF, 8'hFF);
        t_run(8'h0F, 8'h0F, 8'h00);
        t_busy_ignore();
        chk("R3 eight pulses per select", pulse_bad, 0);
        chk("R3 select edges with clock low", ceviol, 0);
        chk("R4 phase times", tviol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vecs++;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule